// File: doc/BRIEF.md
# Rate-Adapting Clock Bridge with Idle Insertion

This block carries 32-bit words from a slower write clock into a faster, unrelated read clock that drives a serial link. A small dual-clock FIFO sits between the two domains. Its write and read pointers cross the boundary in Gray code through two-flop synchronizers. Because the read clock is faster, the FIFO runs dry on some read cycles. On each such cycle the read side emits a filler word, so the link sees one word on every read cycle. Each output word has a flag that marks it as real data or filler, so a downstream encoder and CRC stage can drop or pass the filler.

The block keeps latency small and fixed. The read side stays idle after reset until the fill level it sees has reached a start threshold (default 2 words). After that it takes a word on every read cycle that has one. On the write side, a write attempted while the FIFO is full is dropped, and the attempt sets a sticky overflow flag that a synchronous clear input resets.

Top module: `clk_rate_bridge`

## Requirements
- R1: Every accepted word appears exactly once on `link_data` with `link_valid` = 1, unchanged and in write order.
- R2: After read-side reset, no word is emitted until the read side has seen at least `START_LEVEL` (default 2) words in the FIFO. A single word written alone stays inside.
- R3: Once the first word has been emitted, the start threshold no longer applies: any single word written later is emitted, until the next read-side reset.
- R4: On every read cycle without a word to emit, `link_valid` is 0 and `link_data` is 32'h0000_0000.
- R5: The FIFO holds `DEPTH` (default 8) words. A write attempted while full is dropped, and the stored words still come out intact and in order.
- R6: A write attempted while full sets `ovf_flag` on the next write clock. The flag holds until `ovf_clr` is high on a write clock edge with no overflowing write. If a clear and an overflowing write arrive on the same edge, the flag is set.
- R7: While in reset and right after it, `link_valid`, `link_data` and `ovf_flag` are all 0.
- R8: The fill level seen by the write side never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock (slower) |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DW (32) | Word to transfer |
| ovf_clr | input | 1 | Synchronous clear of the overflow flag |
| ovf_flag | output | 1 | Sticky overflow indication, write domain |
| rd_clk | input | 1 | Read/link-domain clock (faster) |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| link_data | output | DW (32) | Output word, zero when filler |
| link_valid | output | 1 | 1 for a real word, 0 for filler |

## Verification
The bench writes a lone word into a freshly reset bridge. A design that ignored the start threshold would emit that word at once, and one that re-armed the threshold after it drained would later hold back single words. It sweeps burst lengths with gaps and runs a long back-to-back stream, so a pointer that wraps wrongly, a Gray conversion with a bad bit or an off-by-one empty test would show up as lost, repeated or reordered words. With the reader held in reset it writes one word past full. A full test off by one would store or corrupt that word. The bench also checks that the flag stays set, that a clear works, and that a set on the same edge as a clear wins. A design that let stale memory reach the link on filler cycles would fail the zero check on idle words.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t to_bin(input ptr_t g);
    ptr_t r;
    r[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) r[i] = r[i+1] ^ g[i];
    return r;
  endfunction
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/bridge_mem.sv
module bridge_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];
  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end
  assign rdata = cells[raddr];
endmodule

// File: rtl/bridge_wr.sv
module bridge_wr #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          ovf_clr,
  input  logic [PW-1:0] rgray_sync,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          wr_fire,
  output logic          wr_full,
  output logic [PW-1:0] wr_level,
  output logic          ovf
);
  logic [PW-1:0] rbin_s, wbin_nxt;

  assign rbin_s   = PW'(bridge_pkg::to_bin(bridge_pkg::ptr_t'(rgray_sync)));
  assign wr_level = wbin - rbin_s;
  assign wr_full  = (wr_level == PW'(DEPTH));
  assign wr_fire  = wr_en & ~wr_full;
  assign wbin_nxt = wbin + PW'(wr_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bridge_pkg::to_gray(bridge_pkg::ptr_t'(wbin_nxt)));
      ovf   <= (wr_en & wr_full) | (ovf & ~ovf_clr);
    end
  end
endmodule

// File: rtl/bridge_rd.sv
module bridge_rd #(
  parameter int DW          = 32,
  parameter int PW          = 4,
  parameter int START_LEVEL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wgray_sync,
  input  logic [DW-1:0] mem_q,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          rd_fire,
  output logic [PW-1:0] rd_level,
  output logic          primed,
  output logic [DW-1:0] link_data,
  output logic          link_valid
);
  logic [PW-1:0] wbin_s, rbin_nxt;
  logic          go;

  assign wbin_s   = PW'(bridge_pkg::to_bin(bridge_pkg::ptr_t'(wgray_sync)));
  assign rd_level = wbin_s - rbin;
  assign go       = primed | (rd_level >= PW'(START_LEVEL));
  assign rd_fire  = go & (rd_level != '0);
  assign rbin_nxt = rbin + PW'(rd_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin       <= '0;
      rgray      <= '0;
      primed     <= 1'b0;
      link_data  <= '0;
      link_valid <= 1'b0;
    end else begin
      rbin       <= rbin_nxt;
      rgray      <= PW'(bridge_pkg::to_gray(bridge_pkg::ptr_t'(rbin_nxt)));
      primed     <= primed | rd_fire;
      link_valid <= rd_fire;
      link_data  <= rd_fire ? mem_q : '0;
    end
  end
endmodule

// File: rtl/clk_rate_bridge.sv
module clk_rate_bridge #(
  parameter int DW          = 32,
  parameter int DEPTH       = 8,
  parameter int START_LEVEL = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ovf_clr,
  output logic          ovf_flag,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] link_data,
  output logic          link_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_rs, rgray_ws;
  logic [PW-1:0] wr_level, rd_level;
  logic          wr_fire, wr_full, rd_fire, primed;
  logic [DW-1:0] mem_q;

  bridge_wr #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .ovf_clr(ovf_clr),
    .rgray_sync(rgray_ws), .wbin(wbin), .wgray(wgray), .wr_fire(wr_fire),
    .wr_full(wr_full), .wr_level(wr_level), .ovf(ovf_flag)
  );

  bridge_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .raddr(rbin[AW-1:0]), .rdata(mem_q)
  );

  bridge_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rs)
  );

  bridge_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_ws)
  );

  bridge_rd #(.DW(DW), .PW(PW), .START_LEVEL(START_LEVEL)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .wgray_sync(wgray_rs), .mem_q(mem_q),
    .rbin(rbin), .rgray(rgray), .rd_fire(rd_fire), .rd_level(rd_level),
    .primed(primed), .link_data(link_data), .link_valid(link_valid)
  );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_en,
  input logic          wr_full,
  input logic [PW-1:0] wr_level,
  input logic          ovf,
  input logic          ovf_clr,
  input logic          primed,
  input logic          link_valid,
  input logic [DW-1:0] link_data
);
  assert_level_bound_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_level <= PW'(DEPTH));

  assert_idle_zero_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !link_valid |-> link_data == '0);

  assert_ovf_set_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> ovf);

  assert_ovf_hold_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (ovf && !ovf_clr) |=> ovf);

  assert_ovf_clear_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (ovf_clr && !(wr_en && wr_full)) |=> !ovf);

  assert_prime_hold_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    primed |=> primed);

  assert_start_gate_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    link_valid |-> primed);
endmodule

bind clk_rate_bridge bridge_chk #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_en(wr_en), .wr_full(wr_full), .wr_level(wr_level), .ovf(ovf_flag),
  .ovf_clr(ovf_clr), .primed(primed), .link_valid(link_valid),
  .link_data(link_data)
);

// File: tb/clk_rate_bridge_bench.sv
module clk_rate_bridge_bench;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_en = 1'b0, ovf_clr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          ovf_flag, link_valid;
  logic [DW-1:0] link_data;

  always #5 wr_clk = ~wr_clk;  // slower write side, 4/5 of read rate
  always #4 rd_clk = ~rd_clk;  // 125 MHz read side

  clk_rate_bridge #(.DW(DW), .DEPTH(DEPTH), .START_LEVEL(2)) u_clk_rate_bridge (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .link_data(link_data), .link_valid(link_valid)
  );

  int n_tests = 0, n_fail = 0, recv = 0, idle_bad = 0, seq = 0, base;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] mon_e;

  function automatic logic [DW-1:0] pat(input int k);
    logic [15:0] s = k[15:0];
    return {s ^ 16'h5A3C, ~s} + k;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      if (link_valid) begin
        recv++;
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected word", link_data, '0);
        else begin
          mon_e = exp_q.pop_front();
          chk(link_data == mon_e, "R1 word", link_data, mon_e);
        end
      end else if (link_data != '0) idle_bad++;
    end
  end

  task automatic put(input bit keep);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = pat(seq);
    if (keep) exp_q.push_back(pat(seq));
    seq++;
  endtask

  task automatic idle_wr(input int n);
    @(negedge wr_clk);
    wr_en = 1'b0;
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic do_reset(input bit hold_rd);
    wr_en = 1'b0; ovf_clr = 1'b0;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    chk(link_valid == 1'b0, "R7 valid in reset", {31'b0, link_valid}, '0);
    chk(link_data == '0, "R7 data in reset", link_data, '0);
    chk(ovf_flag == 1'b0, "R7 ovf in reset", {31'b0, ovf_flag}, '0);
    exp_q.delete();
    wr_rst_n = 1'b1;
    if (!hold_rd) rd_rst_n = 1'b1;
    @(negedge wr_clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // Phase A: start threshold, single words, bursts, stream
    do_reset(1'b0);
    rd_wait(3);
    chk(link_valid == 1'b0 && link_data == '0, "R7 after reset", link_data, '0);

    put(1'b1); idle_wr(1);
    rd_wait(40);
    chk(recv == 0, "R2 lone word held", recv, 0);
    put(1'b1); idle_wr(1);
    rd_wait(40);
    chk(recv == 2, "R2 threshold reached", recv, 2);

    base = recv;
    put(1'b1); idle_wr(1);
    rd_wait(40);
    chk(recv == base + 1, "R3 single word after start", recv, base + 1);

    for (int len = 1; len <= 12; len++) begin
      for (int i = 0; i < len; i++) put(1'b1);
      idle_wr(len % 3);
    end
    rd_wait(40);
    chk(exp_q.size() == 0, "R1 bursts drained", exp_q.size(), 0);

    base = recv;
    for (int i = 0; i < 300; i++) put(1'b1);
    idle_wr(1);
    rd_wait(40);
    chk(recv == base + 300, "R1 stream count", recv, base + 300);

    // Phase B: full FIFO and overflow, reader held in reset
    do_reset(1'b1);
    for (int i = 0; i < DEPTH; i++) put(1'b1);
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(ovf_flag == 1'b0, "R6 no ovf at exactly full", {31'b0, ovf_flag}, '0);
    wr_en = 1'b1; wr_data = 32'hDEAD_BEEF;  // dropped word
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(ovf_flag == 1'b1, "R6 ovf set", {31'b0, ovf_flag}, 1);
    repeat (5) @(negedge wr_clk);
    chk(ovf_flag == 1'b1, "R6 ovf sticky", {31'b0, ovf_flag}, 1);
    ovf_clr = 1'b1;
    @(negedge wr_clk);
    ovf_clr = 1'b0;
    chk(ovf_flag == 1'b0, "R6 ovf cleared", {31'b0, ovf_flag}, 0);
    ovf_clr = 1'b1; wr_en = 1'b1;
    @(negedge wr_clk);
    ovf_clr = 1'b0; wr_en = 1'b0;
    chk(ovf_flag == 1'b1, "R6 set wins over clear", {31'b0, ovf_flag}, 1);
    ovf_clr = 1'b1;
    @(negedge wr_clk);
    ovf_clr = 1'b0;

    base = recv;
    rd_rst_n = 1'b1;
    rd_wait(40);
    chk(recv == base + DEPTH, "R5 stored words out", recv, base + DEPTH);
    chk(exp_q.size() == 0, "R5 overflow word dropped", exp_q.size(), 0);
    chk(idle_bad == 0, "R4 idle words zero", idle_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule